// File: doc/BRIEF.md
# Endpoint Flush Request Controller

This block carries out flush requests for the endpoints of a USB device controller. Software writes a word with one bit per endpoint and direction. The low half of the word covers the receive endpoints and the high half covers the transmit endpoints. Each bit that is written as 1 starts a flush attempt for that endpoint. The request bit reads back as set while the attempt is pending. Hardware then clears it, whatever the outcome.

The block keeps a primed-status bit for every endpoint and direction. A prime strobe from the descriptor logic sets this bit. A successful flush clears it. The protocol engine drives a per-endpoint packet-in-progress signal. If that signal is still high when an attempt reaches its decision cycle, the flush is refused so that the packet can complete. Software finds out the result by reading the primed-status bit once the request has cleared. It retries by writing the request again.

Top module: `ep_flush_ctrl`

## Requirements
- R1: With `wr_en_i` high, every bit of `wr_data_i` that is 1 sets the matching `flush_req_o` bit at the next clock edge. Bit i (i < NUM_EP) is receive endpoint i. Bit NUM_EP+i is transmit endpoint i.
- R2: A bit written as 0 has no effect. A write of 1 to a request bit that is already set is ignored and does not start a second attempt.
- R3: A set request bit stays high for exactly one cycle, which is the decision cycle. Hardware clears it at the following edge, whether the flush succeeds or is refused.
- R4: Take a decision cycle in which the endpoint's `pkt_active_i` is low and no prime strobe is present. At the following edge, that endpoint's `primed_o` bit is cleared.
- R5: If `pkt_active_i` is high in the decision cycle, the flush is refused and the `primed_o` bit keeps its value.
- R6: A `prime_i` bit sets the matching `primed_o` bit at the next edge. It wins over a flush decided in the same cycle.
- R7: After a refused attempt, writing the same request bit again starts a new attempt. That attempt follows R3 to R5.
- R8: While `rst` is high, and right after reset, `flush_req_o` and `primed_o` are all zero.
- R9: A `primed_o` bit rises only through its prime strobe. A flush never changes the request or primed bits of endpoints that were not requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the flush request word |
| wr_data_i | input | 2*NUM_EP | Write-1-to-request data; receive bits low, transmit bits high |
| prime_i | input | 2*NUM_EP | Per-endpoint prime strobe |
| pkt_active_i | input | 2*NUM_EP | Packet in progress, per endpoint and direction |
| flush_req_o | output | 2*NUM_EP | Pending flush request bits |
| primed_o | output | 2*NUM_EP | Endpoint primed status |

## Verification
A write shows in `flush_req_o` one edge later. The flush decision is taken at the edge after that, and that same edge clears the request bit. The primed bit then shows the outcome, two edges after the write. A prime strobe shows in `primed_o` one edge after it is driven. The bench drives inputs on the falling edge and steps a bench model of both registers at each rising edge. It compares the outputs on the next falling edge, so every result is checked in the cycle in which it is due. Directed cases hold `pkt_active_i` high and low across the decision cycle, and they collide a prime strobe with a flush decision.

// File: rtl/ep_flush_pkg.sv
package ep_flush_pkg;

    localparam int unsigned DEF_NUM_EP = 16;

    typedef enum logic {
        LANE_IDLE   = 1'b0,
        LANE_DECIDE = 1'b1
    } lane_state_e;

    typedef struct packed {
        logic set;    // accepted write-1 request
        logic prime;  // prime strobe
        logic busy;   // packet in progress
    } lane_ctl_t;

    // A flush clears the primed bit only if no packet is active and no prime competes.
    function automatic logic flush_clears(lane_ctl_t c);
        return !c.busy && !c.prime;
    endfunction

endpackage

// File: rtl/ep_flush_wr_decode.sv
module ep_flush_wr_decode #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [WIDTH-1:0] pending_i,
    output logic [WIDTH-1:0] set_o
);
    // Zero bits do nothing, and ones landing on a pending bit are dropped.
    always_comb begin
        set_o = '0;
        if (wr_en_i) begin
            set_o = wr_data_i & ~pending_i;
        end
    end
endmodule

// File: rtl/ep_flush_lane.sv
module ep_flush_lane
    import ep_flush_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_ctl_t ctl_i,
    output logic      req_o,
    output logic      primed_o
);
    lane_state_e state_q;
    logic        primed_q;
    logic        deciding;

    assign deciding = (state_q == LANE_DECIDE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LANE_IDLE;
            primed_q <= 1'b0;
        end else begin
            unique case (state_q)
                LANE_IDLE:   if (ctl_i.set) state_q <= LANE_DECIDE;
                LANE_DECIDE: state_q <= LANE_IDLE;
                default:     state_q <= LANE_IDLE;
            endcase
            if (ctl_i.prime) begin
                primed_q <= 1'b1;
            end else if (deciding && flush_clears(ctl_i)) begin
                primed_q <= 1'b0;
            end
        end
    end

    assign req_o    = deciding;
    assign primed_o = primed_q;
endmodule

// File: rtl/ep_flush_ctrl.sv
module ep_flush_ctrl
    import ep_flush_pkg::*;
#(
    parameter int unsigned NUM_EP = DEF_NUM_EP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [2*NUM_EP-1:0] wr_data_i,
    input  logic [2*NUM_EP-1:0] prime_i,
    input  logic [2*NUM_EP-1:0] pkt_active_i,
    output logic [2*NUM_EP-1:0] flush_req_o,
    output logic [2*NUM_EP-1:0] primed_o
);
    localparam int unsigned W = 2 * NUM_EP;

    logic [W-1:0] set_vec;
    logic [W-1:0] req_vec;
    logic [W-1:0] primed_vec;

    ep_flush_wr_decode #(.WIDTH(W)) u_dec (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .pending_i (req_vec),
        .set_o     (set_vec)
    );

    for (genvar g = 0; g < W; g++) begin : g_lane
        lane_ctl_t ctl;
        always_comb begin
            ctl.set   = set_vec[g];
            ctl.prime = prime_i[g];
            ctl.busy  = pkt_active_i[g];
        end
        ep_flush_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .ctl_i    (ctl),
            .req_o    (req_vec[g]),
            .primed_o (primed_vec[g])
        );
    end

    assign flush_req_o = req_vec;
    assign primed_o    = primed_vec;
endmodule

// File: rtl/ep_flush_ctrl_chk.sv
module ep_flush_ctrl_chk #(
    parameter int unsigned NUM_EP = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en_i,
    input logic [2*NUM_EP-1:0] wr_data_i,
    input logic [2*NUM_EP-1:0] prime_i,
    input logic [2*NUM_EP-1:0] pkt_active_i,
    input logic [2*NUM_EP-1:0] flush_req_o,
    input logic [2*NUM_EP-1:0] primed_o
);
    localparam int unsigned W = 2 * NUM_EP;

    AST_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~flush_req_o & $past({W{wr_en_i}} & wr_data_i & ~flush_req_o)) == '0)); // R1

    AST_REQ_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flush_req_o & ~$past({W{wr_en_i}} & wr_data_i)) == '0)); // R2

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flush_req_o & $past(flush_req_o)) == '0)); // R3

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((primed_o & $past(flush_req_o & ~pkt_active_i & ~prime_i)) == '0)); // R4

    AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~primed_o & $past(flush_req_o & pkt_active_i & primed_o)) == '0)); // R5

    AST_PRIME_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~primed_o & $past(prime_i)) == '0)); // R6

    AST_PRIMED_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((primed_o & ~$past(primed_o) & ~$past(prime_i)) == '0)); // R9
endmodule

bind ep_flush_ctrl ep_flush_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/ep_flush_ctrl_tb.sv
module ep_flush_ctrl_tb;
    localparam int unsigned NUM_EP  = 16;
    localparam int unsigned W       = 2 * NUM_EP;
    localparam time         CLK_PER = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en;
    logic [W-1:0] wr_data, prime, busy;
    logic [W-1:0] flush_req, primed;
    logic [W-1:0] exp_req, exp_primed;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    ep_flush_ctrl #(.NUM_EP(NUM_EP)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .prime_i      (prime),
        .pkt_active_i (busy),
        .flush_req_o  (flush_req),
        .primed_o     (primed)
    );

    function automatic logic [W-1:0] model_req(logic [W-1:0] r, logic we, logic [W-1:0] d);
        return we ? (d & ~r) : '0;
    endfunction

    function automatic logic [W-1:0] model_primed(logic [W-1:0] p, logic [W-1:0] r,
                                                  logic [W-1:0] pr, logic [W-1:0] b);
        return pr | (p & ~(r & ~b));
    endfunction

    task automatic check(string tag);
        checks += 2;
        if (flush_req !== exp_req) begin
            errors++;
            $display("FAIL %s flush_req actual=%h expected=%h", tag, flush_req, exp_req);
        end
        if (primed !== exp_primed) begin
            errors++;
            $display("FAIL %s primed actual=%h expected=%h", tag, primed, exp_primed);
        end
    endtask

    task automatic cyc(logic we, logic [W-1:0] d, logic [W-1:0] pr, logic [W-1:0] b, string tag);
        wr_en = we; wr_data = d; prime = pr; busy = b;
        @(posedge clk);
        exp_primed = model_primed(exp_primed, exp_req, pr, b);
        exp_req    = model_req(exp_req, we, d);
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        wr_en = 1'b0; wr_data = '0; prime = '0; busy = '0;
        exp_req = '0; exp_primed = '0;
        repeat (3) @(negedge clk);
        check("R8 in reset");
        rst = 1'b0;
        cyc(1'b0, '0, '0, '0, "R8 after reset");

        // Prime all endpoints.
        cyc(1'b0, '0, '1, '0, "R6 prime all");
        // Request rx ep3 (bit 3) and tx ep5 (bit 21).
        cyc(1'b1, W'(32'h0020_0008), '0, '0, "R1 set rx3 tx5");
        // Decision: ep3 busy -> refused, tx5 idle -> cleared; rewrite of bit 21 ignored.
        cyc(1'b1, W'(32'h0020_0000), '0, W'(32'h0000_0008), "R3 R5 R2 decision");
        cyc(1'b0, '0, '0, '0, "R9 untouched bits");
        // Zero write has no effect.
        cyc(1'b1, '0, '0, '0, "R2 zero write");
        // Retry ep3 with packet finished.
        cyc(1'b1, W'(32'h0000_0008), '0, W'(32'h0000_0008), "R7 retry set");
        cyc(1'b0, '0, '0, '0, "R7 R4 retry clears");
        // Flush and prime collide on bit 0.
        cyc(1'b1, W'(32'h0000_0001), '0, '0, "R1 set rx0");
        cyc(1'b0, '0, W'(32'h0000_0001), '0, "R6 prime beats flush");
        // Flush of an already-unprimed endpoint stays unprimed.
        cyc(1'b1, W'(32'h0000_0008), '0, '0, "R1 set rx3 again");
        cyc(1'b0, '0, '0, '0, "R4 unprimed stays clear");

        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 3) != 0, W'($urandom) & W'($urandom),
                W'($urandom) & W'($urandom) & W'($urandom), W'($urandom), "R9 R4 R5 random");
        end

        done = 1'b1;
        finish_run();
    end
endmodule